// File: doc/BRIEF.md
# Adaptive Transmit FIFO Trigger Level Controller

This block holds the fill threshold at which a transmit FIFO starts to release buffered data to the medium. The threshold is kept as a count of 64-byte units. It starts at the smallest legal count. A transmit underrun pulses the increase strobe, which moves the threshold halfway toward its ceiling. Software pulses the decrease strobe to lower it by one unit. After each adjustment a one-cycle result pulse reports whether the level moved or was held at a limit.

The adjustment is a two-step sequence. First the current level is captured, then the new level is written. During both steps the block raises an output that holds the global interrupt off, so an interrupt handler never sees a half-updated threshold. When the update ends, that output drops and the global enable returns to whatever state it had before. A simple register port lets software load a level directly and read back the current one. The threshold is also presented in bytes.

Top module: `txtrig_ctrl`

## Requirements
- R1: After reset the level is 1 (64 bytes), `irq_block` is 0 and `upd_done` is 0.
- R2: `thresh_bytes` always equals the current level multiplied by 64.
- R3: A write on `cfg_wr_en` while idle loads `cfg_wr_level` into the level one cycle later, visible on `cfg_rd_level`. Values below the minimum of 1 are loaded as 1.
- R4: An increase takes level L to L + (63 - L) / 2, using integer division, and reports `upd_ok` = 1 when the level changed.
- R5: An increase that leaves the level unchanged (L = 62 or L = 63) reports `upd_ok` = 0.
- R6: A decrease takes L to L - 1 with `upd_ok` = 1. At L = 1 the level stays at 1 and `upd_ok` = 0.
- R7: A request accepted at a clock edge raises `irq_block` for exactly the next two cycles. The new level and a one-cycle `upd_done` pulse appear in the cycle in which `irq_block` falls.
- R8: Strobes and writes that arrive while an update is in progress (`irq_block` = 1) are ignored.
- R9: When both strobes are asserted together, the increase is performed and the decrease is dropped.
- R10: When a write and a strobe are asserted together while idle, the write is applied and the strobe is dropped. No update starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_level | input | 6 | Level to write, in 64-byte units |
| cfg_rd_level | output | 6 | Current level, in 64-byte units |
| thresh_bytes | output | 12 | Current threshold in bytes |
| underrun_inc | input | 1 | Increase request (underrun event) |
| shrink_dec | input | 1 | Decrease request |
| upd_done | output | 1 | One-cycle pulse when an update completes |
| upd_ok | output | 1 | With `upd_done`: 1 if the level moved, 0 if a limit was hit |
| irq_block | output | 1 | Holds the global interrupt off during an update |

## Verification
The hardest situation to create is a request or write that lands in the middle of a busy update. It must leave no trace on the level, on the result pulse or on the mask length. The directed sequences inject such stimulus during each of the two busy cycles and then check the outcome against the model. The limit cases need the level placed at exactly 1, 62 or 63 first. The bench uses the write port to load those values directly, and it also reaches them through chains of random increases and decreases.

// File: rtl/txtrig_pkg.sv
package txtrig_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SNAP  = 2'd1,
        PH_APPLY = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2
    } op_e;
endpackage

// File: rtl/txtrig_req_arb.sv
// Picks the single action taken by an idle controller in a cycle.
// Writes beat strobes; the increase strobe beats the decrease strobe.
module txtrig_req_arb
    import txtrig_pkg::*;
(
    input  logic idle,
    input  logic wr_en,
    input  logic inc_req,
    input  logic dec_req,
    output logic take_wr,
    output op_e  op
);
    always_comb begin
        take_wr = idle && wr_en;
        op      = OP_NONE;
        if (idle && !wr_en) begin
            if (inc_req) begin
                op = OP_INC;
            end else if (dec_req) begin
                op = OP_DEC;
            end
        end
    end
endmodule

// File: rtl/txtrig_wr_clamp.sv
// Forces a software-written level into the legal window.
module txtrig_wr_clamp #(
    parameter int LVL_W   = 6,
    parameter int LVL_MIN = 1,
    parameter int LVL_MAX = 63
) (
    input  logic [LVL_W-1:0] raw,
    output logic [LVL_W-1:0] legal
);
    localparam logic [LVL_W-1:0] MIN_L = LVL_W'(LVL_MIN);
    localparam logic [LVL_W-1:0] MAX_L = LVL_W'(LVL_MAX);

    always_comb begin
        if (raw < MIN_L) begin
            legal = MIN_L;
        end else if (raw > MAX_L) begin
            legal = MAX_L;
        end else begin
            legal = raw;
        end
    end
endmodule

// File: rtl/txtrig_level_step.sv
// Computes the next level for an adjustment and whether it succeeds.
module txtrig_level_step
    import txtrig_pkg::*;
#(
    parameter int LVL_W   = 6,
    parameter int LVL_MIN = 1,
    parameter int LVL_MAX = 63
) (
    input  op_e              op,
    input  logic [LVL_W-1:0] cur,
    output logic [LVL_W-1:0] nxt,
    output logic             ok
);
    localparam logic [LVL_W-1:0] MIN_L = LVL_W'(LVL_MIN);
    localparam logic [LVL_W-1:0] MAX_L = LVL_W'(LVL_MAX);
    localparam logic [LVL_W-1:0] ONE_L = LVL_W'(1);

    logic [LVL_W-1:0] gap;
    logic [LVL_W-1:0] grown;

    always_comb begin
        gap   = (cur < MAX_L) ? (MAX_L - cur) : '0;
        grown = cur + (gap >> 1);
    end

    always_comb begin
        nxt = cur;
        ok  = 1'b0;
        case (op)
            OP_INC: begin
                nxt = grown;
                ok  = (grown != cur);
            end
            OP_DEC: begin
                if (cur > MIN_L) begin
                    nxt = cur - ONE_L;
                    ok  = 1'b1;
                end
            end
            default: begin
                nxt = cur;
                ok  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/txtrig_ctrl.sv
module txtrig_ctrl
    import txtrig_pkg::*;
#(
    parameter int LVL_W     = 6,
    parameter int LVL_MIN   = 1,
    parameter int LVL_MAX   = 63,
    parameter int UNIT_LOG2 = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr_en,
    input  logic [LVL_W-1:0]           cfg_wr_level,
    output logic [LVL_W-1:0]           cfg_rd_level,
    output logic [LVL_W+UNIT_LOG2-1:0] thresh_bytes,
    input  logic                       underrun_inc,
    input  logic                       shrink_dec,
    output logic                       upd_done,
    output logic                       upd_ok,
    output logic                       irq_block
);
    localparam logic [LVL_W-1:0] RST_LVL = LVL_W'(LVL_MIN);

    typedef struct packed {
        phase_e           phase;
        op_e              op;
        logic [LVL_W-1:0] level;
        logic [LVL_W-1:0] snap;
        logic             done;
        logic             ok;
    } state_t;

    state_t st_d, st_q;

    logic             take_wr;
    op_e              new_op;
    logic [LVL_W-1:0] wr_legal;
    logic [LVL_W-1:0] step_lvl;
    logic             step_ok;

    txtrig_req_arb u_arb (
        .idle    (st_q.phase == PH_IDLE),
        .wr_en   (cfg_wr_en),
        .inc_req (underrun_inc),
        .dec_req (shrink_dec),
        .take_wr (take_wr),
        .op      (new_op)
    );

    txtrig_wr_clamp #(
        .LVL_W   (LVL_W),
        .LVL_MIN (LVL_MIN),
        .LVL_MAX (LVL_MAX)
    ) u_clamp (
        .raw   (cfg_wr_level),
        .legal (wr_legal)
    );

    txtrig_level_step #(
        .LVL_W   (LVL_W),
        .LVL_MIN (LVL_MIN),
        .LVL_MAX (LVL_MAX)
    ) u_step (
        .op  (st_q.op),
        .cur (st_q.snap),
        .nxt (step_lvl),
        .ok  (step_ok)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (take_wr) begin
                    st_d.level = wr_legal;
                end else if (new_op != OP_NONE) begin
                    st_d.op    = new_op;
                    st_d.phase = PH_SNAP;
                end
            end
            PH_SNAP: begin
                st_d.snap  = st_q.level;
                st_d.phase = PH_APPLY;
            end
            PH_APPLY: begin
                st_d.level = step_lvl;
                st_d.ok    = step_ok;
                st_d.done  = 1'b1;
                st_d.op    = OP_NONE;
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.op    <= OP_NONE;
            st_q.level <= RST_LVL;
            st_q.snap  <= RST_LVL;
            st_q.done  <= 1'b0;
            st_q.ok    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rd_level = st_q.level;
    assign thresh_bytes = {st_q.level, {UNIT_LOG2{1'b0}}};
    assign upd_done     = st_q.done;
    assign upd_ok       = st_q.ok;
    assign irq_block    = (st_q.phase != PH_IDLE);
endmodule

// File: rtl/txtrig_ctrl_chk.sv
module txtrig_ctrl_chk #(
    parameter int LVL_W     = 6,
    parameter int LVL_MIN   = 1,
    parameter int LVL_MAX   = 63,
    parameter int UNIT_LOG2 = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_wr_en,
    input logic [LVL_W-1:0]           cfg_rd_level,
    input logic [LVL_W+UNIT_LOG2-1:0] thresh_bytes,
    input logic                       upd_done,
    input logic                       upd_ok,
    input logic                       irq_block
);
    // R1, R3: level never leaves its legal window
    p_level_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_level >= LVL_W'(LVL_MIN)) && (cfg_rd_level <= LVL_W'(LVL_MAX)));

    // R2: byte view tracks the unit count
    p_bytes_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh_bytes >> UNIT_LOG2) == (LVL_W+UNIT_LOG2)'(cfg_rd_level));

    // R7: mask lasts exactly two cycles
    p_mask_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_block) |=> irq_block);
    p_mask_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_block && $past(irq_block)) |=> !irq_block);

    // R7: result pulse coincides with the mask falling
    p_done_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> (!irq_block && $past(irq_block)));

    // R8: level only moves after a write or at the end of an update
    p_level_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(irq_block) && !$past(cfg_wr_en)) |-> $stable(cfg_rd_level));

    // R5, R6: a refused update leaves the level alone; a granted one moves it
    p_fail_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !upd_ok) |-> $stable(cfg_rd_level));
    p_ok_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && upd_ok) |-> !$stable(cfg_rd_level));
endmodule

bind txtrig_ctrl txtrig_ctrl_chk #(
    .LVL_W     (LVL_W),
    .LVL_MIN   (LVL_MIN),
    .LVL_MAX   (LVL_MAX),
    .UNIT_LOG2 (UNIT_LOG2)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_rd_level (cfg_rd_level),
    .thresh_bytes (thresh_bytes),
    .upd_done     (upd_done),
    .upd_ok       (upd_ok),
    .irq_block    (irq_block)
);

// File: tb/txtrig_ctrl_bench.sv
module txtrig_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [5:0]  cfg_wr_level = '0;
    logic [5:0]  cfg_rd_level;
    logic [11:0] thresh_bytes;
    logic        underrun_inc = 1'b0;
    logic        shrink_dec = 1'b0;
    logic        upd_done;
    logic        upd_ok;
    logic        irq_block;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_lvl = 1;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    txtrig_ctrl u_txtrig_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_level (cfg_wr_level),
        .cfg_rd_level (cfg_rd_level),
        .thresh_bytes (thresh_bytes),
        .underrun_inc (underrun_inc),
        .shrink_dec   (shrink_dec),
        .upd_done     (upd_done),
        .upd_ok       (upd_ok),
        .irq_block    (irq_block)
    );

    function automatic int f_inc(int c);
        return c + (63 - c) / 2;
    endfunction

    function automatic int f_dec(int c);
        return (c - 1 < 1) ? c : c - 1;
    endfunction

    function automatic int f_clamp(int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_idle_out(string req);
        chk(req, int'(cfg_rd_level), exp_lvl);
        chk("R2", int'(thresh_bytes), exp_lvl * 64);
    endtask

    task automatic wr(int v, bit with_inc, bit with_dec);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_level = 6'(v);
        underrun_inc = with_inc; shrink_dec = with_dec;
        @(negedge clk);
        cfg_wr_en = 1'b0; underrun_inc = 1'b0; shrink_dec = 1'b0;
        exp_lvl = f_clamp(v);
        chk_idle_out("R3");
        if (with_inc || with_dec) begin
            chk("R10", int'(irq_block), 0);
            @(negedge clk);
            chk("R10", int'(irq_block), 0);
            chk("R10", int'(upd_done), 0);
            chk("R10", int'(cfg_rd_level), exp_lvl);
        end
    endtask

    // noise: 0 none, 1 strobe/write in first busy cycle, 2 in second
    task automatic upd(bit inc, bit dec, int noise);
        int  nl;
        bit  nok;
        string rq;
        rq  = inc ? ((inc && dec) ? "R9" : "R4") : "R6";
        nl  = inc ? f_inc(exp_lvl) : f_dec(exp_lvl);
        nok = (nl != exp_lvl);
        if (inc && !nok) rq = "R5";
        @(negedge clk);
        underrun_inc = inc; shrink_dec = dec;
        @(negedge clk);
        underrun_inc = 1'b0; shrink_dec = 1'b0;
        chk("R7", int'(irq_block), 1);
        chk("R7", int'(upd_done), 0);
        if (noise == 1) begin
            cfg_wr_en = 1'b1; cfg_wr_level = 6'd5; shrink_dec = 1'b1;
        end
        @(negedge clk);
        cfg_wr_en = 1'b0; shrink_dec = 1'b0;
        chk("R7", int'(irq_block), 1);
        if (noise != 0) chk("R8", int'(cfg_rd_level), exp_lvl);
        if (noise == 2) begin
            cfg_wr_en = 1'b1; cfg_wr_level = 6'd40; underrun_inc = 1'b1;
        end
        @(negedge clk);
        cfg_wr_en = 1'b0; underrun_inc = 1'b0;
        exp_lvl = nl;
        chk("R7", int'(irq_block), 0);
        chk("R7", int'(upd_done), 1);
        chk(rq, int'(upd_ok), int'(nok));
        chk_idle_out(rq);
        @(negedge clk);
        chk("R7", int'(upd_done), 0);
        if (noise != 0) begin
            chk("R8", int'(irq_block), 0);
            chk("R8", int'(cfg_rd_level), exp_lvl);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", int'(cfg_rd_level), 1);
        chk("R1", int'(irq_block), 0);
        chk("R1", int'(upd_done), 0);
        chk("R2", int'(thresh_bytes), 64);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(cfg_rd_level), 1);

        // directed corners
        upd(1'b0, 1'b1, 0);       // R6 decrease at minimum refused
        upd(1'b1, 1'b0, 0);       // R4 1 -> 32
        upd(1'b0, 1'b1, 0);       // R6 32 -> 31
        wr(0, 1'b0, 1'b0);        // R3 clamp to 1
        wr(62, 1'b0, 1'b0);
        upd(1'b1, 1'b0, 0);       // R5 at 62
        wr(63, 1'b0, 1'b0);
        upd(1'b1, 1'b0, 0);       // R5 at 63
        wr(10, 1'b0, 1'b0);
        upd(1'b1, 1'b1, 0);       // R9 10 -> 36
        wr(20, 1'b1, 1'b0);       // R10
        wr(7, 1'b0, 1'b1);        // R10
        upd(1'b0, 1'b1, 1);       // R8 noise first cycle
        upd(1'b1, 1'b0, 2);       // R8 noise second cycle

        // random mix
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel == 0) begin
                wr(int'($urandom_range(0, 63)), 1'b0, 1'b0);
            end else if (sel < 5) begin
                upd(1'b0, 1'b1, int'($urandom_range(0, 2)));
            end else if (sel < 9) begin
                upd(1'b1, 1'($urandom_range(0, 1)), int'($urandom_range(0, 2)));
            end else begin
                repeat (int'($urandom_range(1, 4))) @(negedge clk);
                chk_idle_out("R8");
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule